// File: doc/BRIEF.md
# Adapter Interrupt Vector Fetch Unit

This block sits inside a bus adapter that connects a device bus to a host. The adapter cannot see the host's current priority, so it never grants the device bus by itself. Each device bus request line is passed upstream as a host interrupt request at the same level. When the host reads the vector register of a level, that read shows the host is ready to take the interrupt. Only then does the unit drive the bus grant for that level. It then waits for a device to return a vector with the interrupt strobe and completes the read with that vector.

A device may drop a grant and return no vector. If no strobe arrives within a timeout window, the unit removes the grant and completes the read with a zero value. Each such zero completion increments a counter. Nothing clears this counter by itself: only a host clear command or the bus reset clears it. When the count reaches its limit, the unit drives a fixed-length bus reset pulse. During the pulse no grant is given and any host read completes at once with zero.

Top module: `vecfetch_unit`

## Requirements
- R1: `host_irq` equals `dev_req` delayed by one clock. A request alone never raises any bit of `dev_grant`.
- R2: A host read of level L (`host_rd` high, `host_lvl` = L) taken while idle and outside a bus reset sets `dev_grant` to one-hot bit L in the next cycle. No more than one grant bit is ever high.
- R3: When `dev_strobe` is sampled high during a grant, `dev_vec` is latched on that cycle. The grant stays high until the strobe is sampled low. In the cycle after that, the grant falls and `host_rdy` pulses with `host_data` equal to the latched vector.
- R4: If no strobe is sampled during the first TIMEOUT cycles of a grant, the grant falls after exactly TIMEOUT cycles. At the same time `host_rdy` pulses with `host_data` = 0.
- R5: Each R4 timeout completion increments the zero-vector count. Completions that carry a vector leave the count unchanged.
- R6: The completion that brings the count to ZLIMIT raises `bus_reset` in the same cycle as its `host_rdy`. `bus_reset` stays high for exactly RST_CYC cycles, and the count returns to zero.
- R7: A cycle with `host_clr_zc` high sets the count to zero, so ZLIMIT further timeouts are needed before the next bus reset.
- R8: While `bus_reset` is high, `dev_grant` stays zero. A host read completes in the next cycle with `host_rdy` high and `host_data` = 0, and it does not add to the count.
- R9: Only one fetch is active at a time. `host_lvl` is sampled only when a read is accepted, and changing it during a fetch does not move the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NLVL | Device bus request lines, one per level |
| host_irq | output | NLVL | Upstream interrupt requests |
| host_rd | input | 1 | Host vector-register read, held until `host_rdy` |
| host_lvl | input | clog2(NLVL) | Level whose vector register is read |
| host_clr_zc | input | 1 | Host command that clears the zero-vector count |
| host_rdy | output | 1 | One-cycle read completion |
| host_data | output | VW | Read data: the vector, or zero |
| dev_grant | output | NLVL | Device bus grant lines, one-hot |
| dev_strobe | input | 1 | Device interrupt strobe |
| dev_vec | input | VW | Vector driven by the device with the strobe |
| bus_reset | output | 1 | Device bus reset pulse |

## Verification
The hardest state to reach from the ports is a bus reset pulse that is still active when a host read arrives. Reaching it takes a long string of grants that no device answers, and the string must not be broken by a clear. The bench sets the threshold and the timeout to small values. It lets random fetches, some answered and some not, drive the count to the limit, and in some cases it issues a read just as the pulse starts. It checks the pulse length, the zero completion, and that the count starts again from zero afterwards.

// File: rtl/vf_pkg.sv
package vf_pkg;

  typedef enum logic [1:0] {FS_IDLE, FS_GRANT, FS_DROP} fetch_state_t;

  // Timer value at which an unanswered grant is given up.
  function automatic logic timer_expired(input int unsigned tval, input int unsigned limit);
    return tval == limit - 1;
  endfunction

  // Zero-vector count update: a clear wins, reaching the limit wraps to zero.
  function automatic int unsigned zc_next(input int unsigned cnt, input logic inc,
                                          input logic clr, input int unsigned limit);
    if (clr) return 0;
    if (inc) return (cnt + 1 >= limit) ? 0 : cnt + 1;
    return cnt;
  endfunction

  function automatic logic zc_trip(input int unsigned cnt, input logic inc,
                                   input logic clr, input int unsigned limit);
    return !clr && inc && (cnt + 1 >= limit);
  endfunction

endpackage

// File: rtl/vf_irq_fwd.sv
module vf_irq_fwd #(
  parameter int NLVL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_in,
  output logic [NLVL-1:0] irq_out
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) irq_out[g] <= 1'b0;
      else        irq_out[g] <= req_in[g];
    end
  end
endmodule

// File: rtl/vf_fetch_ctrl.sv
module vf_fetch_ctrl
  import vf_pkg::*;
#(
  parameter int NLVL    = 4,
  parameter int VW      = 16,
  parameter int TIMEOUT = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_rd,
  input  logic [$clog2(NLVL)-1:0] host_lvl,
  input  logic                    dev_strobe,
  input  logic [VW-1:0]           dev_vec,
  input  logic                    in_reset,
  output logic [NLVL-1:0]         dev_grant,
  output logic                    host_rdy,
  output logic [VW-1:0]           host_data,
  output logic                    zero_evt,
  output logic                    vec_take
);
  localparam int LW = $clog2(NLVL);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  fetch_state_t   state;
  logic [TW-1:0]  tmr;
  logic [NLVL-1:0] lvl_dec;
  logic           expired;

  for (genvar g = 0; g < NLVL; g++) begin : g_dec
    assign lvl_dec[g] = (host_lvl == LW'(g));
  end

  assign expired  = timer_expired(int'(tmr), TIMEOUT);
  assign vec_take = (state == FS_GRANT) && !in_reset && dev_strobe;
  assign zero_evt = (state == FS_GRANT) && !in_reset && !dev_strobe && expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      tmr       <= '0;
      dev_grant <= '0;
      host_rdy  <= 1'b0;
      host_data <= '0;
    end else begin
      host_rdy <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (host_rd) begin
            if (in_reset) begin
              host_rdy  <= 1'b1;
              host_data <= '0;
            end else begin
              dev_grant <= lvl_dec;
              tmr       <= '0;
              state     <= FS_GRANT;
            end
          end
        end
        FS_GRANT: begin
          if (in_reset || zero_evt) begin
            dev_grant <= '0;
            host_rdy  <= 1'b1;
            host_data <= '0;
            state     <= FS_IDLE;
          end else if (vec_take) begin
            host_data <= dev_vec;
            state     <= FS_DROP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        FS_DROP: begin
          if (in_reset) begin
            dev_grant <= '0;
            host_rdy  <= 1'b1;
            host_data <= '0;
            state     <= FS_IDLE;
          end else if (!dev_strobe) begin
            dev_grant <= '0;
            host_rdy  <= 1'b1;
            state     <= FS_IDLE;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vf_zero_monitor.sv
module vf_zero_monitor
  import vf_pkg::*;
#(
  parameter int ZLIMIT  = 250000,
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic clr_cmd,
  output logic bus_reset
);
  localparam int ZW = $clog2(ZLIMIT + 1);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [ZW-1:0] zcnt;
  logic [PW-1:0] pcnt;
  logic          trip;

  assign trip = zc_trip(int'(zcnt), zero_evt, clr_cmd, ZLIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt      <= '0;
      pcnt      <= '0;
      bus_reset <= 1'b0;
    end else if (bus_reset) begin
      zcnt <= '0;
      pcnt <= pcnt + 1'b1;
      if (pcnt == PW'(RST_CYC - 1)) bus_reset <= 1'b0;
    end else begin
      zcnt <= ZW'(zc_next(int'(zcnt), zero_evt, clr_cmd, ZLIMIT));
      if (trip) begin
        bus_reset <= 1'b1;
        pcnt      <= '0;
      end
    end
  end
endmodule

// File: rtl/vecfetch_unit.sv
module vecfetch_unit #(
  parameter int NLVL    = 4,
  parameter int VW      = 16,
  parameter int TIMEOUT = 64,
  parameter int ZLIMIT  = 250000,
  parameter int RST_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLVL-1:0]         dev_req,
  output logic [NLVL-1:0]         host_irq,
  input  logic                    host_rd,
  input  logic [$clog2(NLVL)-1:0] host_lvl,
  input  logic                    host_clr_zc,
  output logic                    host_rdy,
  output logic [VW-1:0]           host_data,
  output logic [NLVL-1:0]         dev_grant,
  input  logic                    dev_strobe,
  input  logic [VW-1:0]           dev_vec,
  output logic                    bus_reset
);
  logic zero_evt;
  logic vec_take;

  vf_irq_fwd #(.NLVL(NLVL)) u_fwd (
    .clk(clk), .rst_n(rst_n), .req_in(dev_req), .irq_out(host_irq)
  );

  vf_fetch_ctrl #(.NLVL(NLVL), .VW(VW), .TIMEOUT(TIMEOUT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_lvl(host_lvl),
    .dev_strobe(dev_strobe), .dev_vec(dev_vec), .in_reset(bus_reset),
    .dev_grant(dev_grant), .host_rdy(host_rdy), .host_data(host_data),
    .zero_evt(zero_evt), .vec_take(vec_take)
  );

  vf_zero_monitor #(.ZLIMIT(ZLIMIT), .RST_CYC(RST_CYC)) u_zmon (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .clr_cmd(host_clr_zc),
    .bus_reset(bus_reset)
  );
endmodule

// File: rtl/vf_checker.sv
module vf_checker #(
  parameter int NLVL    = 4,
  parameter int VW      = 16,
  parameter int TIMEOUT = 64,
  parameter int RST_CYC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLVL-1:0] dev_req,
  input logic [NLVL-1:0] host_irq,
  input logic            host_rd,
  input logic            host_rdy,
  input logic [VW-1:0]   host_data,
  input logic [NLVL-1:0] dev_grant,
  input logic            bus_reset,
  input logic            zero_evt,
  input logic            vec_take
);
  int unsigned age;
  logic        taken;
  int unsigned plen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= 0; taken <= 1'b0; plen <= 0;
    end else begin
      if (dev_grant == '0) begin
        age <= 0; taken <= 1'b0;
      end else begin
        if (!taken) age <= age + 1;
        if (vec_take) taken <= 1'b1;
      end
      plen <= bus_reset ? plen + 1 : 0;
    end
  end

  p_irq_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> host_irq == $past(dev_req));

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));

  p_grant_from_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant != '0 && $past(dev_grant) == '0) |-> $past(host_rd));

  p_vec_holds_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> dev_grant == $past(dev_grant));

  p_zero_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> host_rdy && host_data == '0 && dev_grant == '0);

  p_grant_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant != '0 && !taken) |-> age < TIMEOUT);

  p_pulse_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> plen < RST_CYC);

  p_no_grant_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> dev_grant == '0);
endmodule

bind vecfetch_unit vf_checker #(.NLVL(NLVL), .VW(VW), .TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .host_irq(host_irq), .host_rd(host_rd),
  .host_rdy(host_rdy), .host_data(host_data), .dev_grant(dev_grant), .bus_reset(bus_reset),
  .zero_evt(zero_evt), .vec_take(vec_take)
);

// File: tb/tb_vecfetch_unit.sv
module tb_vecfetch_unit;
  localparam int CLK_P = 10;
  localparam int NL = 4;
  localparam int VWB = 16;
  localparam int TO = 8;
  localparam int ZL = 5;
  localparam int RC = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NL-1:0]  dev_req = '0;
  logic [NL-1:0]  host_irq;
  logic           host_rd = 1'b0;
  logic [1:0]     host_lvl = '0;
  logic           host_clr_zc = 1'b0;
  logic           host_rdy;
  logic [VWB-1:0] host_data;
  logic [NL-1:0]  dev_grant;
  logic           dev_strobe = 1'b0;
  logic [VWB-1:0] dev_vec = '0;
  logic           bus_reset;

  int checks = 0;
  int fails = 0;
  int zc = 0;

  always #(CLK_P/2) clk = ~clk;

  vecfetch_unit #(.NLVL(NL), .VW(VWB), .TIMEOUT(TO), .ZLIMIT(ZL), .RST_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .host_irq(host_irq), .host_rd(host_rd),
    .host_lvl(host_lvl), .host_clr_zc(host_clr_zc), .host_rdy(host_rdy),
    .host_data(host_data), .dev_grant(dev_grant), .dev_strobe(dev_strobe),
    .dev_vec(dev_vec), .bus_reset(bus_reset)
  );

  function automatic logic [NL-1:0] exp_grant(input int lvl);
    return NL'(1) << lvl;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Count the pulse (first high cycle already seen), optionally reading inside it.
  task automatic measure_pulse(input bit rd_in_rst);
    int n = 1;
    if (rd_in_rst) begin
      host_rd = 1'b1; host_lvl = 2'd2;
      @(negedge clk); n++;
      chk(host_rdy && host_data == 0 && dev_grant == 0, "R8 read in reset",
          {host_rdy, host_data, dev_grant}, {1'b1, 16'h0, 4'h0});
      host_rd = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (!bus_reset) break;
      n++;
      chk(dev_grant == 0, "R8 grant in reset", dev_grant, 0);
    end
    chk(n == RC, "R6 pulse length", n, RC);
  endtask

  task automatic do_fetch(input int lvl, input bit strb, input int d, input int h,
                          input logic [VWB-1:0] vec, input bit rd_in_rst);
    host_rd = 1'b1; host_lvl = 2'(lvl);
    @(negedge clk);
    chk(dev_grant == exp_grant(lvl) && !host_rdy, "R2 grant on read", dev_grant, exp_grant(lvl));
    if (strb) begin
      repeat (d) @(negedge clk);
      dev_strobe = 1'b1; dev_vec = vec;
      @(negedge clk);
      host_lvl = 2'(lvl) ^ 2'd1;   // R9: level changes mid-fetch must not matter
      dev_vec = ~vec;
      repeat (h) @(negedge clk);
      chk(dev_grant == exp_grant(lvl) && !host_rdy, "R9 R3 grant held", dev_grant, exp_grant(lvl));
      dev_strobe = 1'b0; dev_vec = $urandom_range(0, 16'hffff);
      @(negedge clk);
      chk(host_rdy && host_data == vec && dev_grant == 0, "R3 vector returned", host_data, vec);
      chk(!bus_reset, "R5 vector not counted", bus_reset, 0);
      host_rd = 1'b0;
    end else begin
      repeat (TO - 1) @(negedge clk);
      chk(dev_grant == exp_grant(lvl) && !host_rdy, "R4 grant before timeout", dev_grant, exp_grant(lvl));
      @(negedge clk);
      chk(host_rdy && host_data == 0 && dev_grant == 0, "R4 zero completion",
          {host_rdy, host_data, dev_grant}, {1'b1, 16'h0, 4'h0});
      zc++;
      chk(bus_reset == (zc == ZL), "R5 R6 reset at limit", bus_reset, zc == ZL);
      host_rd = 1'b0;
      if (zc == ZL) begin
        zc = 0;
        measure_pulse(rd_in_rst);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(dev_grant == 0 && !host_rdy && !bus_reset && host_irq == 0, "R1 R2 reset state",
        {dev_grant, host_rdy, bus_reset}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: forwarding, no grant from requests alone
    for (int i = 0; i < 6; i++) begin
      logic [NL-1:0] r = NL'($urandom_range(0, 15));
      dev_req = r;
      @(negedge clk);
      chk(host_irq == r, "R1 irq forward", host_irq, r);
      chk(dev_grant == 0, "R1 no self grant", dev_grant, 0);
    end
    dev_req = '0;

    // R2/R3 each level, strobe at latest legal cycle
    for (int l = 0; l < NL; l++) do_fetch(l, 1'b1, TO - 1, 1, 16'h1000 + 16'(l), 1'b0);

    // R7: three timeouts, clear, four timeouts -> no reset, one more -> reset
    for (int i = 0; i < 3; i++) do_fetch(i, 1'b0, 0, 0, 0, 1'b0);
    host_clr_zc = 1'b1; @(negedge clk); host_clr_zc = 1'b0; zc = 0;
    for (int i = 0; i < ZL - 1; i++) do_fetch(3, 1'b0, 0, 0, 0, 1'b0);
    chk(!bus_reset, "R7 clear delays reset", bus_reset, 0);
    do_fetch(1, 1'b0, 0, 0, 0, 1'b1);   // R6 with R8 read inside pulse

    // Random mix
    for (int i = 0; i < 40; i++) begin
      do_fetch($urandom_range(0, NL - 1), $urandom_range(0, 1) == 1,
               $urandom_range(0, TO - 2), $urandom_range(0, 3),
               16'($urandom_range(1, 16'hffff)), $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule